// File: doc/BRIEF.md
# Unaligned byte-stream write packer

This block turns a byte-granular write request into a sequence of aligned 32-bit program operations. A host presents a start byte offset and a byte count on a request port, then streams the bytes one per handshake. The block groups the bytes into words at addresses that are multiples of four. It presents each word with its address on a valid/ready program port, then waits for a pass/fail response before it goes on.

Lanes that the request does not cover are set to 0xFF, so that programming leaves those cells in their erased state. This applies to the lanes below an unaligned start and the lanes above a short end. A count of committed bytes grows only when a word is reported as passed. The operation ends at the first failed word, with an error code that tells a failed word apart from a request that falls outside the device.

Controller states: IDLE (waits for a request), FILL (takes stream bytes into the word being built), ISSUE (offers the word on the program port), WAIT (waits for the pass/fail response) and DONE (a one-cycle completion pulse). The transitions are:
- IDLE to DONE when the request is empty or out of range.
- IDLE to FILL for any other request.
- FILL to ISSUE when the last byte of a word is taken, or the last byte of the request.
- ISSUE to WAIT when the program port accepts the word.
- WAIT to FILL on a pass while bytes remain.
- WAIT to DONE on a pass with no bytes remaining, or on a fail.
- DONE to IDLE always.

Top module: `bytepack_wr`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `pgm_valid` and `done` are 0, `committed` is 0 and `err_code` is 0.
- R2: Every word goes to an address with its two low bits zero. When the start offset is not aligned, the first word goes to the offset rounded down to 4, and its lanes below the offset hold 0xFF. Lane k of `pgm_data` is bits 8k+7:8k and carries the byte at the word address plus k.
- R3: The first word takes request bytes up to the next word boundary or to the end of the request, whichever comes first. Its lanes above the last byte hold 0xFF.
- R4: After the first word, each group of four bytes is issued as one full word, at word addresses that increase by 4.
- R5: When fewer than four bytes remain after the full words, they fill the low lanes of one final word, and the remaining lanes hold 0xFF.
- R6: A request with a byte count of 0 raises `done` in the cycle after it is accepted. It issues no word, `err_code` is 0 and `committed` is 0.
- R7: A request whose offset plus byte count exceeds DEV_BYTES raises `done` in the cycle after it is accepted. It issues no word, `err_code` is 1 and `committed` is 0.
- R8: A fail response ends the operation in the next cycle with `err_code` 2. No further word is issued, and `committed` equals the bytes of the words that passed before it.
- R9: `committed` changes only at request acceptance (to 0) and in the cycle after a pass response, when it grows by the bytes in that word. A fully successful request ends with `committed` equal to its byte count and `err_code` 0.
- R10: While `pgm_valid` is high and `pgm_ready` is low, the word and its address hold steady. No stream byte is taken while a word is outstanding.
- R11: `done` is high for exactly one cycle per request. `req_ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_offset | input | ADDR_W | Start byte offset |
| req_len | input | ADDR_W+1 | Byte count |
| in_valid | input | 1 | Stream byte offered |
| in_ready | output | 1 | Stream byte taken this cycle if valid |
| in_data | input | 8 | Stream byte |
| pgm_valid | output | 1 | Word offered to the program port |
| pgm_ready | input | 1 | Program port accepts the word |
| pgm_addr | output | ADDR_W | Aligned word address |
| pgm_data | output | 8*WORD_BYTES | Packed word, lane 0 in the low byte |
| pgm_resp_valid | input | 1 | Response for the outstanding word |
| pgm_resp_fail | input | 1 | 1 = word failed, 0 = passed |
| done | output | 1 | One-cycle completion pulse |
| committed | output | ADDR_W+1 | Bytes in words that passed |
| err_code | output | 2 | 0 none, 1 range rejected, 2 program failure |

## Verification
The assertions assume that the program port returns exactly one response per accepted word, and only while that word is outstanding. A response outside the wait state is ignored by the design, but the assertions on failure timing would then be meaningless. The bench's program-port model enforces this: it raises `pgm_ready` for one cycle after a varying stall and drives the response in the following cycle. The byte driver stops offering bytes once it sees the completion pulse, so a failed request never leaves stream bytes pending against the next request.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } bpk_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RANGE = 2'd1,
        ERR_PGM   = 2'd2
    } bpk_err_e;

endpackage

// File: rtl/bpk_range_chk.sv
module bpk_range_chk #(
    parameter int ADDR_W    = 12,
    parameter int LEN_W     = 13,
    parameter int DEV_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [LEN_W-1:0]  len,
    output logic              is_empty,
    output logic              out_of_range
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] end_pos;

    always_comb begin
        end_pos      = SUM_W'(offset) + SUM_W'(len);
        is_empty     = (len == '0);
        out_of_range = (end_pos > SUM_W'(DEV_BYTES));
    end
endmodule

// File: rtl/bpk_lane_asm.sv
module bpk_lane_asm #(
    parameter int WORD_BYTES = 4,
    parameter int LANE_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic [LANE_W-1:0]       start_lane,
    input  logic                    take,
    input  logic [7:0]              byte_in,
    output logic [WORD_BYTES*8-1:0] word,
    output logic [LANE_W-1:0]       lane,
    output logic [LANE_W:0]         fill_cnt
);
    // One register per lane; a cleared lane reads as erased (all ones)
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= 8'hFF;
            else if (clear)
                lane_q <= 8'hFF;
            else if (take && lane == LANE_W'(g))
                lane_q <= byte_in;
        end
        assign word[g*8 +: 8] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane     <= '0;
            fill_cnt <= '0;
        end else if (clear) begin
            lane     <= start_lane;
            fill_cnt <= '0;
        end else if (take) begin
            lane     <= lane + LANE_W'(1);
            fill_cnt <= fill_cnt + (LANE_W+1)'(1);
        end
    end
endmodule

// File: rtl/bpk_fsm.sv
module bpk_fsm
    import bpk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       is_empty,
    input  logic       out_of_range,
    input  logic       in_valid,
    input  logic       last_in_word,
    input  logic       remain_zero,
    input  logic       pgm_ready,
    input  logic       resp_valid,
    input  logic       resp_fail,
    output logic       req_ready,
    output logic       accept,
    output logic       in_ready,
    output logic       take,
    output logic       pgm_valid,
    output logic       word_pass,
    output logic       word_fail,
    output logic       done
);
    bpk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid)
                    state_d = (is_empty || out_of_range) ? ST_DONE : ST_FILL;
            ST_FILL:
                if (in_valid && last_in_word)
                    state_d = ST_ISSUE;
            ST_ISSUE:
                if (pgm_ready)
                    state_d = ST_WAIT;
            ST_WAIT:
                if (resp_valid) begin
                    if (resp_fail || remain_zero)
                        state_d = ST_DONE;
                    else
                        state_d = ST_FILL;
                end
            ST_DONE:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        in_ready  = (state_q == ST_FILL);
        take      = in_ready && in_valid;
        pgm_valid = (state_q == ST_ISSUE);
        word_pass = (state_q == ST_WAIT) && resp_valid && !resp_fail;
        word_fail = (state_q == ST_WAIT) && resp_valid && resp_fail;
        done      = (state_q == ST_DONE);
    end
endmodule

// File: rtl/bytepack_wr.sv
module bytepack_wr
    import bpk_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DEV_BYTES  = 4096,
    parameter int WORD_BYTES = 4,
    localparam int LEN_W     = ADDR_W + 1,
    localparam int DATA_W    = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              pgm_valid,
    input  logic              pgm_ready,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    input  logic              pgm_resp_valid,
    input  logic              pgm_resp_fail,
    output logic              done,
    output logic [LEN_W-1:0]  committed,
    output logic [1:0]        err_code
);
    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

    logic              is_empty, out_of_range;
    logic              accept, take, word_pass, word_fail;
    logic              last_in_word, remain_zero, asm_clear;
    logic [LANE_W-1:0] lane, start_lane;
    logic [LANE_W:0]   fill_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q, committed_q;
    bpk_err_e          err_q;

    bpk_range_chk #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .DEV_BYTES (DEV_BYTES)
    ) u_range (
        .offset       (req_offset),
        .len          (req_len),
        .is_empty     (is_empty),
        .out_of_range (out_of_range)
    );

    assign last_in_word = (lane == LANE_W'(WORD_BYTES - 1)) || (remain_q == LEN_W'(1));
    assign remain_zero  = (remain_q == '0);

    bpk_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .is_empty     (is_empty),
        .out_of_range (out_of_range),
        .in_valid     (in_valid),
        .last_in_word (last_in_word),
        .remain_zero  (remain_zero),
        .pgm_ready    (pgm_ready),
        .resp_valid   (pgm_resp_valid),
        .resp_fail    (pgm_resp_fail),
        .req_ready    (req_ready),
        .accept       (accept),
        .in_ready     (in_ready),
        .take         (take),
        .pgm_valid    (pgm_valid),
        .word_pass    (word_pass),
        .word_fail    (word_fail),
        .done         (done)
    );

    assign asm_clear  = accept || word_pass;
    assign start_lane = accept ? req_offset[LANE_W-1:0] : '0;

    bpk_lane_asm #(
        .WORD_BYTES (WORD_BYTES),
        .LANE_W     (LANE_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (asm_clear),
        .start_lane (start_lane),
        .take       (take),
        .byte_in    (in_data),
        .word       (pgm_data),
        .lane       (lane),
        .fill_cnt   (fill_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            remain_q    <= '0;
            committed_q <= '0;
            err_q       <= ERR_NONE;
        end else if (accept) begin
            addr_q      <= req_offset & ALIGN_MASK;
            remain_q    <= req_len;
            committed_q <= '0;
            err_q       <= (!is_empty && out_of_range) ? ERR_RANGE : ERR_NONE;
        end else begin
            if (take)
                remain_q <= remain_q - LEN_W'(1);
            if (word_pass) begin
                committed_q <= committed_q + LEN_W'(fill_cnt);
                addr_q      <= addr_q + ADDR_W'(WORD_BYTES);
            end
            if (word_fail)
                err_q <= ERR_PGM;
        end
    end

    assign pgm_addr  = addr_q;
    assign committed = committed_q;
    assign err_code  = err_q;
endmodule

// File: rtl/bpk_checker.sv
module bpk_checker #(
    parameter int ADDR_W    = 12,
    parameter int DEV_BYTES = 4096,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_offset,
    input logic [ADDR_W:0]   req_len,
    input logic              in_ready,
    input logic              pgm_valid,
    input logic              pgm_ready,
    input logic [ADDR_W-1:0] pgm_addr,
    input logic [DATA_W-1:0] pgm_data,
    input logic              pgm_resp_valid,
    input logic              pgm_resp_fail,
    input logic              done,
    input logic [ADDR_W:0]   committed,
    input logic [1:0]        err_code
);
    localparam int SUM_W = ADDR_W + 2;

    logic req_oor;
    assign req_oor = (req_len != '0) &&
                     ((SUM_W'(req_offset) + SUM_W'(req_len)) > SUM_W'(DEV_BYTES));

    // R10
    pgm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_valid && !pgm_ready |=> pgm_valid && $stable(pgm_addr) && $stable(pgm_data));

    // R10
    no_take_while_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_valid |-> !in_ready);

    // R2
    pgm_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_valid |-> pgm_addr[1:0] == 2'b00);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_valid || in_ready || done) |-> !req_ready);

    // R7
    range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_oor |=> done && err_code == 2'd1 && !pgm_valid);

    // R8
    fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_resp_valid && pgm_resp_fail && !pgm_valid && !in_ready && !req_ready && !done
        |=> done && err_code == 2'd2 && $stable(committed));

    // R9
    commit_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && req_ready) && committed != $past(committed)
        |-> $past(pgm_resp_valid && !pgm_resp_fail));
endmodule

bind bytepack_wr bpk_checker #(
    .ADDR_W    (ADDR_W),
    .DEV_BYTES (DEV_BYTES),
    .DATA_W    (DATA_W)
) u_bpk_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_offset     (req_offset),
    .req_len        (req_len),
    .in_ready       (in_ready),
    .pgm_valid      (pgm_valid),
    .pgm_ready      (pgm_ready),
    .pgm_addr       (pgm_addr),
    .pgm_data       (pgm_data),
    .pgm_resp_valid (pgm_resp_valid),
    .pgm_resp_fail  (pgm_resp_fail),
    .done           (done),
    .committed      (committed),
    .err_code       (err_code)
);

// File: tb/bytepack_wr_test.sv
`timescale 1ns/1ps
module bytepack_wr_test;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 13;
    localparam int DEV    = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_offset = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = '0;
    logic              pgm_valid;
    logic              pgm_ready = 1'b0;
    logic [ADDR_W-1:0] pgm_addr;
    logic [31:0]       pgm_data;
    logic              pgm_resp_valid = 1'b0;
    logic              pgm_resp_fail = 1'b0;
    logic              done;
    logic [LEN_W-1:0]  committed;
    logic [1:0]        err_code;

    always #4 clk = ~clk;

    bytepack_wr uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_len(req_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pgm_valid(pgm_valid), .pgm_ready(pgm_ready),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .pgm_resp_valid(pgm_resp_valid), .pgm_resp_fail(pgm_resp_fail),
        .done(done), .committed(committed), .err_code(err_code)
    );

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [31:0]       d;
    } exp_word_t;

    exp_word_t   exp_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          fail_at = -1;
    int          word_idx = 0;
    int          stall = 0;
    bit          op_over = 1'b0;
    logic [LEN_W-1:0] got_cnt;
    logic [1:0]       got_err;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Program-port model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pgm_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected word at address", longint'(pgm_addr), 0);
                end else begin
                    exp_word_t e;
                    e = exp_q.pop_front();
                    chk(pgm_addr == e.a, "R2,R4", "word address", longint'(pgm_addr), longint'(e.a));
                    chk(pgm_data == e.d, "R2,R3,R5", "word data", longint'(pgm_data), longint'(e.d));
                end
                repeat (stall) @(negedge clk);
                stall = (stall + 1) % 3;
                pgm_ready = 1'b1;
                @(negedge clk);
                pgm_ready = 1'b0;
                pgm_resp_valid = 1'b1;
                pgm_resp_fail  = (word_idx == fail_at);
                word_idx++;
                @(negedge clk);
                pgm_resp_valid = 1'b0;
                pgm_resp_fail  = 1'b0;
            end
        end
    end

    // Completion capture
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                op_over = 1'b1;
                got_cnt = committed;
                got_err = err_code;
            end
        end
    end

    task automatic run_op(int off, int len, int fa, int seed);
        logic [7:0] b[$];
        int counts[$];
        int exp_cnt;
        int exp_err;
        bit no_words;
        logic [31:0] w;
        int cur_a;
        int cnt;
        for (int i = 0; i < len; i++) b.push_back(8'(seed * 29 + i * 53 + 7));
        no_words = (len == 0) || (off + len > DEV);
        exp_q.delete();
        if (!no_words) begin
            cur_a = off & ~3;
            w = '1;
            cnt = 0;
            for (int i = 0; i < len; i++) begin
                int a = off + i;
                int wa = a & ~3;
                if (wa != cur_a) begin
                    exp_q.push_back('{ADDR_W'(cur_a), w});
                    counts.push_back(cnt);
                    cur_a = wa;
                    w = '1;
                    cnt = 0;
                end
                w[(a % 4) * 8 +: 8] = b[i];
                cnt++;
            end
            exp_q.push_back('{ADDR_W'(cur_a), w});
            counts.push_back(cnt);
        end
        if (len == 0) begin
            exp_cnt = 0; exp_err = 0;
        end else if (off + len > DEV) begin
            exp_cnt = 0; exp_err = 1;
        end else if (fa >= 0 && fa < counts.size()) begin
            exp_cnt = 0;
            for (int k = 0; k < fa; k++) exp_cnt += counts[k];
            exp_err = 2;
        end else begin
            exp_cnt = len; exp_err = 0;
        end

        fail_at  = fa;
        word_idx = 0;
        op_over  = 1'b0;
        chk(req_ready == 1'b1, "R11", "ready while idle", longint'(req_ready), 1);
        req_valid  = 1'b1;
        req_offset = ADDR_W'(off);
        req_len    = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (no_words) begin
            if (len == 0)
                chk(done == 1'b1, "R6", "done right after empty request", longint'(done), 1);
            else
                chk(done == 1'b1, "R7", "done right after range reject", longint'(done), 1);
        end else begin
            for (int i = 0; i < len; i++) begin
                in_valid = 1'b1;
                in_data  = b[i];
                while (!in_ready && !op_over) @(negedge clk);
                if (op_over) break;
                @(negedge clk);
                in_valid = 1'b0;
            end
            in_valid = 1'b0;
        end
        while (!op_over) @(negedge clk);
        if (exp_err == 2)
            chk(got_cnt == LEN_W'(exp_cnt), "R8", "committed after fail", longint'(got_cnt), exp_cnt);
        else if (exp_err == 1)
            chk(got_cnt == LEN_W'(exp_cnt), "R7", "committed after reject", longint'(got_cnt), exp_cnt);
        else
            chk(got_cnt == LEN_W'(exp_cnt), "R9", "committed after success", longint'(got_cnt), exp_cnt);
        chk(got_err == 2'(exp_err), exp_err == 2 ? "R8" : (exp_err == 1 ? "R7" : "R9"),
            "error code", longint'(got_err), exp_err);
        if (exp_err != 2)
            chk(exp_q.size() == 0, "R4", "words not issued", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11", "back to idle after done",
            longint'({done, req_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready in reset", longint'(req_ready), 1);
        chk(pgm_valid == 1'b0 && done == 1'b0, "R1", "pgm_valid/done in reset",
            longint'({pgm_valid, done}), 0);
        chk(committed == '0 && err_code == 2'd0, "R1", "committed/err in reset",
            longint'({committed, err_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(0, 8, -1, 1);      // R4 aligned full words
        run_op(1, 2, -1, 2);      // R3 head word padded on both sides
        run_op(3, 10, -1, 3);     // R2 R4 R5 head, full, tail
        run_op(6, 3, -1, 4);      // R5 two-lane head and one-byte tail
        run_op(5, 0, -1, 5);      // R6 empty request
        run_op(4090, 7, -1, 6);   // R7 one byte past the end
        run_op(4090, 6, -1, 7);   // R7 boundary: ends exactly at the device end
        run_op(2, 11, 2, 8);      // R8 fail on third word
        run_op(9, 5, 0, 9);       // R8 fail on first word
        run_op(13, 40, -1, 10);   // R9 longer run
        run_op(0, 1, -1, 11);     // R3 R5 single byte
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule